// File: doc/BRIEF.md
# I2C SCL Low/High Count Calculator

This block turns a clock rate and a requested bus rate, all in kHz, into the two count words that an I2C clock generator loads to set the low and high phases of SCL. A pulse on `start` captures the inputs. The block picks a speed band, runs the needed integer divisions on one shared shift-subtract divider, applies the band's duty cycle and offsets, clamps each field to its width, and presents both packed words together with a one-cycle `done`.

Standard rate splits the period evenly. Fast rate and high-speed rate put one third of the period in the high phase and the rest in the low phase. In the high-speed band the block also computes a second pair for the high-speed phase, taken from the functional clock. This pair goes in the upper byte of each word. The lower byte carries the pair for the initial fast-rate phase, taken from the internal clock at 400 kHz. Every division is bit-serial, so no divide operator is inferred.

Top module: `scl_count_calc`

## Requirements
- R1: The band comes from `speed_khz` captured at start. Above 400 selects high-speed, above 100 (up to 400) selects fast, and 100 or below (including 0) selects standard.
- R2: In standard band, with q = floor(int_clk_khz / (2·speed_khz)), the low field is q−7 and the high field is q−5.
- R3: In fast band, with p = floor(int_clk_khz / speed_khz) and t = floor(p/3), the low field is p−t−7 and the high field is t−5.
- R4: In high-speed band, the lower fields follow R3 with p = floor(int_clk_khz/400). The upper fields follow R3 with p = floor(fn_clk_khz/speed_khz).
- R5: Each word packs the high-speed field in bits [15:8] and the standard/fast field in bits [7:0]. `low_word` carries low fields and `high_word` carries high fields.
- R6: Outside the high-speed band, bits [15:8] of both words are zero.
- R7: A field below 0 becomes 0 and a field above 255 becomes 255. `range_err` is 1 with a result exactly when at least one field was clamped, and is 0 otherwise.
- R8: `done` is high for exactly one cycle, in the first cycle a new result appears on the words. The words and `range_err` hold between results.
- R9: A `start` pulse while a calculation is running is ignored: it neither alters the result in progress nor produces an extra result.
- R10: After reset both words are 0, `range_err` is 0 and `done` is 0.
- R11: A division by zero yields an all-ones quotient. A standard-band request with speed 0 therefore gives 255 in both lower fields and raises `range_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a calculation when idle |
| int_clk_khz | input | 32 | Internal clock rate in kHz |
| fn_clk_khz | input | 32 | Functional clock rate in kHz |
| speed_khz | input | 16 | Requested bus rate in kHz |
| low_word | output | 16 | Packed low-phase counts |
| high_word | output | 16 | Packed high-phase counts |
| range_err | output | 1 | A field was clamped |
| done | output | 1 | One-cycle result strobe |

## Verification
The bench builds the block with its default widths: a 32-bit dividend, a 16-bit rate and 8-bit fields. With these widths, rates of 0 and 10 kHz are in range. A 10 kHz standard request gives a quotient of 600, which must clamp to 255, and a small internal clock drives a field below zero. A zero rate drives the divider into its all-ones quotient. The 16-bit rate also reaches both band edges (100/101 and 400/401) and the top high-speed rates. A second start fired in the middle of a four-division high-speed run shows that mid-run starts are ignored.

// File: rtl/scl_count_calc.sv
module scl_count_calc #(
  parameter int CLK_W      = 32,
  parameter int SPD_W      = 16,
  parameter int FLD_W      = 8,
  parameter int FS_RATE    = 400,
  parameter int HS_ABOVE   = 400,
  parameter int FAST_ABOVE = 100,
  parameter int OFS_LO     = 7,
  parameter int OFS_HI     = 5
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic [CLK_W-1:0]   int_clk_khz,
  input  logic [CLK_W-1:0]   fn_clk_khz,
  input  logic [SPD_W-1:0]   speed_khz,
  output logic [2*FLD_W-1:0] low_word,
  output logic [2*FLD_W-1:0] high_word,
  output logic               range_err,
  output logic               done
);
  localparam int CNT_W = $clog2(CLK_W + 1);
  localparam int WW    = CLK_W + 2;
  localparam logic signed [WW-1:0] LO_W   = WW'(OFS_LO);
  localparam logic signed [WW-1:0] HI_W   = WW'(OFS_HI);
  localparam logic signed [WW-1:0] FMAX_W = WW'((1 << FLD_W) - 1);
  localparam logic [1:0] MD_STD = 2'd0, MD_FAST = 2'd1, MD_HS = 2'd2;

  typedef enum logic [2:0] {S_IDLE, S_LOAD, S_DIV, S_STORE, S_FIN} st_t;
  st_t st;

  logic [1:0]       op, mode_q, mode_in, last_op;
  logic [CLK_W-1:0] int_q, fclk_q;
  logic [SPD_W-1:0] spd_q;
  logic [CLK_W-1:0] rem, quo, dsr, op_dvd, op_dsr;
  logic [CNT_W-1:0] cnt;
  logic [CLK_W-1:0] res [4];

  assign mode_in = (speed_khz > SPD_W'(HS_ABOVE))   ? MD_HS :
                   (speed_khz > SPD_W'(FAST_ABOVE)) ? MD_FAST : MD_STD;
  assign last_op = (mode_q == MD_HS) ? 2'd3 : (mode_q == MD_FAST) ? 2'd1 : 2'd0;

  always_comb begin
    case (op)
      2'd0: op_dvd = int_q;
      2'd1: op_dvd = res[0];
      2'd2: op_dvd = fclk_q;
      default: op_dvd = res[2];
    endcase
    case (op)
      2'd0: op_dsr = (mode_q == MD_HS)  ? CLK_W'(FS_RATE) :
                     (mode_q == MD_STD) ? CLK_W'({spd_q, 1'b0}) : CLK_W'(spd_q);
      2'd2: op_dsr = CLK_W'(spd_q);
      default: op_dsr = CLK_W'(3);
    endcase
  end

  logic [CLK_W:0]   sh;
  logic [CLK_W+1:0] diff;
  logic             ge;
  assign sh   = {rem, quo[CLK_W-1]};
  assign diff = {1'b0, sh} - {2'b00, dsr};
  assign ge   = !diff[CLK_W+1];

  function automatic logic [FLD_W:0] sat_f(input logic signed [WW-1:0] v);
    if (v < 0)           return {1'b1, {FLD_W{1'b0}}};
    else if (v > FMAX_W) return {1'b1, {FLD_W{1'b1}}};
    else                 return {1'b0, v[FLD_W-1:0]};
  endfunction

  logic signed [WW-1:0] r0, r1, r2, r3;
  logic [FLD_W:0] fs_lo, fs_hi, hs_lo, hs_hi;
  assign r0 = $signed({2'b00, res[0]});
  assign r1 = $signed({2'b00, res[1]});
  assign r2 = $signed({2'b00, res[2]});
  assign r3 = $signed({2'b00, res[3]});
  assign fs_lo = (mode_q == MD_STD) ? sat_f(r0 - LO_W) : sat_f(r0 - r1 - LO_W);
  assign fs_hi = (mode_q == MD_STD) ? sat_f(r0 - HI_W) : sat_f(r1 - HI_W);
  assign hs_lo = (mode_q == MD_HS)  ? sat_f(r2 - r3 - LO_W) : '0;
  assign hs_hi = (mode_q == MD_HS)  ? sat_f(r3 - HI_W) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE;
      op <= '0;
      mode_q <= MD_STD;
      int_q <= '0;
      fclk_q <= '0;
      spd_q <= '0;
      rem <= '0;
      quo <= '0;
      dsr <= '0;
      cnt <= '0;
      for (int i = 0; i < 4; i++) res[i] <= '0;
      low_word <= '0;
      high_word <= '0;
      range_err <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          int_q  <= int_clk_khz;
          fclk_q <= fn_clk_khz;
          spd_q  <= speed_khz;
          mode_q <= mode_in;
          op     <= '0;
          st     <= S_LOAD;
        end
        S_LOAD: begin
          rem <= '0;
          quo <= op_dvd;
          dsr <= op_dsr;
          cnt <= CNT_W'(CLK_W);
          st  <= S_DIV;
        end
        S_DIV: begin
          rem <= ge ? diff[CLK_W-1:0] : sh[CLK_W-1:0];
          quo <= {quo[CLK_W-2:0], ge};
          cnt <= cnt - 1'b1;
          if (cnt == CNT_W'(1)) st <= S_STORE;
        end
        S_STORE: begin
          res[op] <= quo;
          if (op == last_op) st <= S_FIN;
          else begin
            op <= op + 1'b1;
            st <= S_LOAD;
          end
        end
        S_FIN: begin
          low_word  <= {hs_lo[FLD_W-1:0], fs_lo[FLD_W-1:0]};
          high_word <= {hs_hi[FLD_W-1:0], fs_hi[FLD_W-1:0]};
          range_err <= fs_lo[FLD_W] | fs_hi[FLD_W] | hs_lo[FLD_W] | hs_hi[FLD_W];
          done      <= 1'b1;
          st        <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(low_word) && $stable(high_word) && $stable(range_err)));

  assert_upper_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && mode_q != MD_HS) |-> (low_word[2*FLD_W-1:FLD_W] == '0 && high_word[2*FLD_W-1:FLD_W] == '0));

  assert_clamp_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && range_err) |->
      (low_word[FLD_W-1:0] == '0 || low_word[FLD_W-1:0] == '1 ||
       high_word[FLD_W-1:0] == '0 || high_word[FLD_W-1:0] == '1 ||
       low_word[2*FLD_W-1:FLD_W] == '0 || low_word[2*FLD_W-1:FLD_W] == '1 ||
       high_word[2*FLD_W-1:FLD_W] == '0 || high_word[2*FLD_W-1:FLD_W] == '1));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st != S_IDLE && start) |=> ($stable(spd_q) && $stable(int_q) && $stable(mode_q)));

  assert_rem_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DIV && dsr != '0) |-> (rem < dsr));
endmodule

// File: tb/scl_count_calc_tb_top.sv
module scl_count_calc_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
  logic [31:0] int_clk_khz = '0, fn_clk_khz = '0;
  logic [15:0] speed_khz = '0;
  logic [15:0] low_word, high_word;
  logic range_err, done;

  always #10 clk = ~clk;

  scl_count_calc dut_i (
    .clk(clk), .rst_n(rst_n), .start(start),
    .int_clk_khz(int_clk_khz), .fn_clk_khz(fn_clk_khz), .speed_khz(speed_khz),
    .low_word(low_word), .high_word(high_word), .range_err(range_err), .done(done)
  );

  typedef struct packed {
    logic [15:0] lo;
    logic [15:0] hi;
    logic        err;
    logic [7:0]  tag;
  } exp_t;

  exp_t exp_q[$];
  int checks = 0, fails = 0, results = 0, pushed = 0;
  bit prev_done = 0, finished = 0;

  function automatic longint sat(input longint v, inout bit e);
    if (v < 0) begin e = 1; return 0; end
    if (v > 255) begin e = 1; return 255; end
    return v;
  endfunction

  function automatic exp_t model(input longint ic, input longint fc, input longint sp, input int tag);
    longint a, b, c, d, fl, fh, hl, hh;
    bit e = 0;
    exp_t x;
    hl = 0; hh = 0;
    if (sp > 400) begin
      a = ic / 400; b = a / 3; c = fc / sp; d = c / 3;
      fl = a - b - 7; fh = b - 5; hl = c - d - 7; hh = d - 5;
    end else if (sp > 100) begin
      a = ic / sp; b = a / 3;
      fl = a - b - 7; fh = b - 5;
    end else begin
      a = (sp == 0) ? 64'hFFFF_FFFF : ic / (2 * sp);
      fl = a - 7; fh = a - 5;
    end
    fl = sat(fl, e); fh = sat(fh, e); hl = sat(hl, e); hh = sat(hh, e);
    x.lo = {hl[7:0], fl[7:0]};
    x.hi = {hh[7:0], fh[7:0]};
    x.err = e;
    x.tag = tag[7:0];
    return x;
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (done && prev_done) begin
        checks++; fails++;
        $display("FAIL R8: done high two cycles, actual=1 expected=0");
      end
      if (done) begin
        results++;
        checks++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R9: unexpected result lo=%h hi=%h, expected none", low_word, high_word);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (low_word !== e.lo || high_word !== e.hi || range_err !== e.err) begin
            fails++;
            $display("FAIL R%0d: actual lo=%h hi=%h err=%b expected lo=%h hi=%h err=%b",
                     e.tag, low_word, high_word, range_err, e.lo, e.hi, e.err);
          end
        end
      end
      prev_done <= done;
    end
  end

  task automatic run_case(input int ic, input int fc, input int sp, input int tag);
    exp_q.push_back(model(ic, fc, sp, tag));
    pushed++;
    @(negedge clk);
    int_clk_khz = ic; fn_clk_khz = fc; speed_khz = sp[15:0]; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic check_val(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (act !== expv) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check_val("R10", {low_word, high_word}, 32'h0);
    check_val("R10", {30'b0, range_err, done}, 32'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_val("R10", {low_word, high_word}, 32'h0);

    run_case(12000, 96000, 100, 2);    // R2 standard, band edge R1
    run_case(12000, 96000, 101, 1);    // R1 fast at lower edge
    run_case(12000, 96000, 400, 3);    // R3 fast upper edge
    run_case(19200, 96000, 250, 3);    // R3
    run_case(12000, 96000, 401, 4);    // R4 high-speed lower edge
    run_case(12000, 96000, 3400, 5);   // R5 packing
    run_case(48000, 192000, 1700, 4);  // R4
    run_case(24000, 96000, 50, 6);     // R6 upper bytes zero
    run_case(12000, 96000, 10, 7);     // R7 clamp high
    run_case(1000, 96000, 100, 7);     // R7 clamp low
    run_case(12000, 1000, 3400, 7);    // R7 high-speed fields clamp low
    run_case(12000, 96000, 0, 11);     // R11 divide by zero

    // R8: words hold after result
    @(negedge clk);
    check_val("R8", {low_word, high_word}, 32'hFFFF_FFFF & {model(12000,96000,0,11).lo, model(12000,96000,0,11).hi});

    // R9: second start while busy ignored
    exp_q.push_back(model(12000, 96000, 3400, 9));
    pushed++;
    @(negedge clk);
    int_clk_khz = 12000; fn_clk_khz = 96000; speed_khz = 16'd3400; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (20) @(negedge clk);
    int_clk_khz = 5000; fn_clk_khz = 7000; speed_khz = 16'd80; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (300) @(negedge clk);
    check_val("R9", results, pushed);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule